// File: doc/BRIEF.md
# Gate-Driver Fault Conditioning Unit

This unit sits between the fault comparators of a three-phase gate driver and the rest of the control logic. It takes digital fault flags and turns them into clean, latched events. The flags come from a per-phase desaturation detector, a per-phase phase-error detector, one overcurrent comparator and a set of thermal-warning sensors. Each gate transition opens a blanking window on that phase, during which its desaturation and phase-error flags are ignored. Every source must then persist for its own number of time-base cycles before it counts.

Desaturation, phase-error and overcurrent events are held in sticky status bits until a clear command arrives while the condition is gone. A latched desaturation or overcurrent event raises a shutdown request for the gate controller. Thermal warnings never do. The thermal status bits show the live, filtered state of each sensor on its own, and they show it whatever the mask. A mask register selects which status bits drive the interrupt. The interrupt stays low until the internal supply is reported good.

All inputs are synchronous to the internal time-base clock. Every duration is a parameter given in cycles of that clock.

Top module: `fault_cond_unit`

## Requirements
- R1: A gate_edge pulse on phase p blanks the desaturation and phase-error flags of phase p. The blanking covers the cycle of the pulse and the BLANK_CYC cycles after it. While blanked, the flags count as absent and restart their filters.
- R2: Desaturation on phase p sets status bit p. It does so only after DESAT_FILT consecutive unblanked samples, and the bit appears one cycle after the last of those samples. A run one sample shorter sets nothing.
- R3: Phase error on phase p sets status bit PHASES+p after PHERR_FILT consecutive unblanked samples, with the same one-cycle latency. A shorter run sets nothing.
- R4: Overcurrent sets status bit 2*PHASES after OC_FILT consecutive samples, with the same one-cycle latency. Overcurrent is never blanked. A shorter run sets nothing.
- R5: Bits 0 to 2*PHASES stay set until a clear_faults pulse arrives in a cycle where the filtered condition for that bit is absent. A clear given while the condition is still present leaves the bit set.
- R6: Status bit 2*PHASES+1+t shows the filtered state of thermal sensor t and is never latched. It rises after THERM_FILT consecutive high samples. It falls after THERM_FILT consecutive low samples. The mask has no effect on it.
- R7: shutdown_req is high exactly while any desaturation or overcurrent status bit is set. Phase-error and thermal bits never raise it.
- R8: fault_irq is registered. One cycle after the status changes, it equals supply_ok AND the OR of (status AND mask), where mask bit i gates status bit i. A mask write takes effect on the next cycle.
- R9: After reset, status, mask, fault_irq and shutdown_req are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal time-base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Internal supply powered up; gates the interrupt |
| gate_edge | input | PHASES | One-cycle pulse per phase on each gate output transition |
| desat_raw | input | PHASES | Desaturation comparator flags |
| pherr_raw | input | PHASES | Phase-error comparator flags |
| ocur_raw | input | 1 | Overcurrent comparator flag |
| therm_raw | input | THERMS | Thermal-warning comparator flags |
| clear_faults | input | 1 | One-cycle clear-status command |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 2*PHASES+1+THERMS | Mask value to write |
| fault_status | output | 2*PHASES+1+THERMS | Status readback |
| fault_irq | output | 1 | Interrupt request |
| shutdown_req | output | 1 | Request to force the gates off |

## Verification
The assertions assume that every input is synchronous to clk, and that gate_edge and clear_faults are single-cycle strobes. They also assume that the mask is written only through mask_we. Under those assumptions, a shutdown request can drop only after a clear, and a latched bit can fall only after a clear. The stimulus changes every input on the falling clock edge, pulses the strobes for exactly one cycle, and holds each fault flag for a counted number of cycles. This places every persistence run exactly at its threshold or one sample short of it.

// File: rtl/fbi_pkg.sv
package fbi_pkg;

   // Source class of a fault flag, used to index stimulus and layout.
   typedef enum logic [1:0] {
      SRC_DESAT = 2'd0,
      SRC_PHERR = 2'd1,
      SRC_OCUR  = 2'd2,
      SRC_THERM = 2'd3
   } fault_src_e;

   // Bits needed to hold the value maxval (at least one).
   function automatic int unsigned cnt_bits(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/fbi_persist_filter.sv
module fbi_persist_filter #(
   parameter int unsigned HOLD_CYC     = 4,
   parameter bit          RELEASE_FILT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_i,
   output logic out_o
);
   localparam int unsigned     CW   = fbi_pkg::cnt_bits(HOLD_CYC - 1);
   localparam logic [CW-1:0]   LAST = CW'(HOLD_CYC - 1);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("fbi_persist_filter: HOLD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   generate
      if (RELEASE_FILT) begin : g_symmetric
         // Both directions need HOLD_CYC consecutive samples.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               out_o <= 1'b0;
            end else if (in_i == out_o) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
               out_o <= in_i;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else begin : g_fast_release
         // Assert after HOLD_CYC samples, release on the first low sample.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               out_o <= 1'b0;
            end else if (!in_i) begin
               cnt_q <= '0;
               out_o <= 1'b0;
            end else if (cnt_q == LAST) begin
               out_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   // R2/R3/R4/R6: a rising output always follows a present input sample.
   assert_persist_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_o) |-> $past(in_i));

endmodule

// File: rtl/fbi_blank_timer.sv
module fbi_blank_timer #(
   parameter int unsigned BLANK_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   output logic blank_o
);
   generate
      if (BLANK_CYC == 0) begin : g_no_blank
         assign blank_o = 1'b0;
      end else begin : g_timer
         localparam int unsigned   CW   = fbi_pkg::cnt_bits(BLANK_CYC);
         localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (edge_i)        cnt_q <= LOAD;
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end

         assign blank_o = edge_i | (cnt_q != '0);

         // R1: the cycle after a transition is still inside the window.
         assert_blank_open_R1 : assert property (@(posedge clk) disable iff (!rst_n)
            edge_i |=> blank_o);
      end
   endgenerate

endmodule

// File: rtl/fbi_status_bank.sv
module fbi_status_bank #(
   parameter int unsigned     LW        = 7,
   parameter int unsigned     TW        = 3,
   parameter logic [LW-1:0]   TRIP_MASK = '1,
   localparam int unsigned    SW        = LW + TW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] filt_i,
   input  logic [TW-1:0] therm_i,
   input  logic          clr_i,
   input  logic          supply_ok_i,
   input  logic          mask_we_i,
   input  logic [SW-1:0] mask_d_i,
   output logic [SW-1:0] status_o,
   output logic          irq_o,
   output logic          trip_o
);
   logic [LW-1:0] lat_q;
   logic [SW-1:0] mask_q;

   if (LW < 1 || TW < 1) begin : g_bad_width
      $error("fbi_status_bank: both fields need at least one bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q  <= '0;
         mask_q <= '0;
         irq_o  <= 1'b0;
      end else begin
         lat_q <= (lat_q & ~({LW{clr_i}} & ~filt_i)) | filt_i;
         if (mask_we_i) mask_q <= mask_d_i;
         irq_o <= supply_ok_i & (|(status_o & mask_q));
      end
   end

   assign status_o = {therm_i, lat_q};
   assign trip_o   = |(lat_q & TRIP_MASK);

   // R5: a latched bit only ever falls after a clear command.
   assert_sticky_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(lat_q) & ~lat_q)) |-> $past(clr_i));

   // R8: no interrupt in the cycle after the supply was not good.
   assert_irq_gated_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(supply_ok_i) |-> !irq_o);

endmodule

// File: rtl/fault_cond_unit.sv
module fault_cond_unit #(
   parameter int unsigned PHASES             = 3,
   parameter int unsigned THERMS             = 3,
   parameter int unsigned BLANK_CYC          = 100,
   parameter int unsigned DESAT_FILT         = 17,
   parameter int unsigned PHERR_FILT         = 17,
   parameter int unsigned OC_FILT            = 34,
   parameter int unsigned THERM_FILT         = 340,
   parameter bit          THERM_RELEASE_FILT = 1'b1,
   localparam int unsigned LW = 2 * PHASES + 1,
   localparam int unsigned SW = LW + THERMS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic [PHASES-1:0] gate_edge,
   input  logic [PHASES-1:0] desat_raw,
   input  logic [PHASES-1:0] pherr_raw,
   input  logic              ocur_raw,
   input  logic [THERMS-1:0] therm_raw,
   input  logic              clear_faults,
   input  logic              mask_we,
   input  logic [SW-1:0]     mask_wdata,
   output logic [SW-1:0]     fault_status,
   output logic              fault_irq,
   output logic              shutdown_req
);
   localparam int unsigned   OC_BIT    = 2 * PHASES;
   // Desaturation and overcurrent trip the gates; phase error only reports.
   localparam logic [LW-1:0] TRIP_MASK = {1'b1, {PHASES{1'b0}}, {PHASES{1'b1}}};

   if (PHASES < 1 || PHASES > 8) begin : g_bad_phases
      $error("fault_cond_unit: PHASES out of range 1..8");
   end
   if (THERMS < 1 || THERMS > 8) begin : g_bad_therms
      $error("fault_cond_unit: THERMS out of range 1..8");
   end

   logic [LW-1:0]     filt;
   logic [THERMS-1:0] therm_filt;

   generate
      for (genvar p = 0; p < PHASES; p++) begin : g_phase
         logic blank;

         fbi_blank_timer #(.BLANK_CYC(BLANK_CYC)) i_blank (
            .clk     (clk),
            .rst_n   (rst_n),
            .edge_i  (gate_edge[p]),
            .blank_o (blank)
         );

         fbi_persist_filter #(.HOLD_CYC(DESAT_FILT), .RELEASE_FILT(1'b0)) i_desat (
            .clk   (clk),
            .rst_n (rst_n),
            .in_i  (desat_raw[p] & ~blank),
            .out_o (filt[p])
         );

         fbi_persist_filter #(.HOLD_CYC(PHERR_FILT), .RELEASE_FILT(1'b0)) i_pherr (
            .clk   (clk),
            .rst_n (rst_n),
            .in_i  (pherr_raw[p] & ~blank),
            .out_o (filt[PHASES + p])
         );
      end

      for (genvar t = 0; t < THERMS; t++) begin : g_therm
         fbi_persist_filter #(.HOLD_CYC(THERM_FILT), .RELEASE_FILT(THERM_RELEASE_FILT)) i_therm (
            .clk   (clk),
            .rst_n (rst_n),
            .in_i  (therm_raw[t]),
            .out_o (therm_filt[t])
         );
      end
   endgenerate

   fbi_persist_filter #(.HOLD_CYC(OC_FILT), .RELEASE_FILT(1'b0)) i_ocur (
      .clk   (clk),
      .rst_n (rst_n),
      .in_i  (ocur_raw),
      .out_o (filt[OC_BIT])
   );

   fbi_status_bank #(.LW(LW), .TW(THERMS), .TRIP_MASK(TRIP_MASK)) i_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .filt_i      (filt),
      .therm_i     (therm_filt),
      .clr_i       (clear_faults),
      .supply_ok_i (supply_ok),
      .mask_we_i   (mask_we),
      .mask_d_i    (mask_wdata),
      .status_o    (fault_status),
      .irq_o       (fault_irq),
      .trip_o      (shutdown_req)
   );

   // R7: the shutdown request is only withdrawn after a clear command.
   assert_trip_release_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shutdown_req) |-> $past(clear_faults));

endmodule

// File: tb/test_fault_cond_unit.sv
module test_fault_cond_unit;
   import fbi_pkg::*;

   localparam int unsigned P  = 3;
   localparam int unsigned T  = 3;
   localparam int unsigned BL = 6;
   localparam int unsigned DF = 4;
   localparam int unsigned PF = 5;
   localparam int unsigned OF = 3;
   localparam int unsigned TF = 8;
   localparam int unsigned SW = 2 * P + 1 + T;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          supply_ok = 1'b0;
   logic [P-1:0]  gate_edge = '0;
   logic [P-1:0]  desat_raw = '0;
   logic [P-1:0]  pherr_raw = '0;
   logic          ocur_raw = 1'b0;
   logic [T-1:0]  therm_raw = '0;
   logic          clear_faults = 1'b0;
   logic          mask_we = 1'b0;
   logic [SW-1:0] mask_wdata = '0;
   logic [SW-1:0] fault_status;
   logic          fault_irq;
   logic          shutdown_req;

   int n_cmp  = 0;
   int n_bad  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   fault_cond_unit #(
      .PHASES(P), .THERMS(T), .BLANK_CYC(BL), .DESAT_FILT(DF),
      .PHERR_FILT(PF), .OC_FILT(OF), .THERM_FILT(TF), .THERM_RELEASE_FILT(1'b1)
   ) i_fault_cond_unit (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .gate_edge(gate_edge),
      .desat_raw(desat_raw), .pherr_raw(pherr_raw), .ocur_raw(ocur_raw),
      .therm_raw(therm_raw), .clear_faults(clear_faults), .mask_we(mask_we),
      .mask_wdata(mask_wdata), .fault_status(fault_status),
      .fault_irq(fault_irq), .shutdown_req(shutdown_req)
   );

   // Stimulus vectors: {source[12:11], index[10:9], hold cycles[8:1], expect[0]}
   localparam logic [12:0] VEC [9] = '{
      {SRC_DESAT, 2'd0, 8'd3, 1'b0},
      {SRC_DESAT, 2'd0, 8'd4, 1'b1},
      {SRC_DESAT, 2'd2, 8'd4, 1'b1},
      {SRC_PHERR, 2'd1, 8'd4, 1'b0},
      {SRC_PHERR, 2'd1, 8'd5, 1'b1},
      {SRC_OCUR,  2'd0, 8'd2, 1'b0},
      {SRC_OCUR,  2'd0, 8'd3, 1'b1},
      {SRC_THERM, 2'd0, 8'd7, 1'b0},
      {SRC_THERM, 2'd2, 8'd8, 1'b1}
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pulse_clear();
      clear_faults = 1'b1;
      step(1);
      clear_faults = 1'b0;
   endtask

   task automatic write_mask(input logic [SW-1:0] m);
      mask_we = 1'b1;
      mask_wdata = m;
      step(1);
      mask_we = 1'b0;
   endtask

   task automatic set_raw(input fault_src_e k, input int i, input logic v);
      case (k)
         SRC_DESAT: desat_raw[i] = v;
         SRC_PHERR: pherr_raw[i] = v;
         SRC_OCUR:  ocur_raw     = v;
         default:   therm_raw[i] = v;
      endcase
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R9: reset state
      check("R9 status", 32'(fault_status), 32'h0);
      check("R9 irq", 32'(fault_irq), 32'h0);
      check("R9 shutdown", 32'(shutdown_req), 32'h0);
      supply_ok = 1'b1;

      // Table walk: persistence thresholds per source.
      for (int v = 0; v < 9; v++) begin
         fault_src_e k = fault_src_e'(VEC[v][12:11]);
         int idx = int'(VEC[v][10:9]);
         int len = int'(VEC[v][8:1]);
         logic ex = VEC[v][0];
         string rq;
         int pos;
         case (k)
            SRC_DESAT: begin rq = "R2 desat";  pos = idx;             end
            SRC_PHERR: begin rq = "R3 pherr";  pos = P + idx;         end
            SRC_OCUR:  begin rq = "R4 ocur";   pos = 2 * P;           end
            default:   begin rq = "R6 therm";  pos = 2 * P + 1 + idx; end
         endcase
         set_raw(k, idx, 1'b1);
         step(len);
         if (k == SRC_THERM) begin
            check(rq, 32'(fault_status[pos]), 32'(ex));
            set_raw(k, idx, 1'b0);
         end else begin
            set_raw(k, idx, 1'b0);
            step(1);
            check(rq, 32'(fault_status[pos]), 32'(ex));
            check("R7 shutdown", 32'(shutdown_req), 32'((k != SRC_PHERR) && ex));
         end
         step(TF + 2);
         pulse_clear();
         step(2);
      end

      // R1: blanking after a transition on phase 0, then the filter restarts.
      gate_edge[0] = 1'b1;
      desat_raw[0] = 1'b1;
      step(1);
      gate_edge[0] = 1'b0;
      step(10);
      check("R1 blanked", 32'(fault_status[0]), 32'h0);
      step(1);
      check("R1 after window", 32'(fault_status[0]), 32'h1);
      check("R7 desat trip", 32'(shutdown_req), 32'h1);
      desat_raw[0] = 1'b0;
      step(2);
      pulse_clear();
      step(2);

      // R5: clear while present is refused; clear when absent takes effect.
      desat_raw[1] = 1'b1;
      step(DF + 1);
      check("R2 latched", 32'(fault_status[1]), 32'h1);
      pulse_clear();
      check("R5 clear while present", 32'(fault_status[1]), 32'h1);
      desat_raw[1] = 1'b0;
      step(2);
      check("R5 sticky", 32'(fault_status[1]), 32'h1);
      check("R8 masked no irq", 32'(fault_irq), 32'h0);
      pulse_clear();
      check("R5 cleared", 32'(fault_status[1]), 32'h0);
      check("R7 released", 32'(shutdown_req), 32'h0);

      // R8: unmasked phase error raises the interrupt one cycle after status.
      write_mask(SW'(1) << P);
      pherr_raw[0] = 1'b1;
      step(PF);
      pherr_raw[0] = 1'b0;
      step(1);
      check("R3 latched", 32'(fault_status[P]), 32'h1);
      check("R8 irq latency", 32'(fault_irq), 32'h0);
      step(1);
      check("R8 irq set", 32'(fault_irq), 32'h1);
      check("R7 pherr no trip", 32'(shutdown_req), 32'h0);
      pulse_clear();
      step(1);
      check("R8 irq cleared", 32'(fault_irq), 32'h0);

      // R6: thermal live bit, mask gating, release filter.
      write_mask('0);
      therm_raw[1] = 1'b1;
      step(TF + 3);
      check("R6 therm live", 32'(fault_status[2 * P + 2]), 32'h1);
      check("R6 masked no irq", 32'(fault_irq), 32'h0);
      check("R7 therm no trip", 32'(shutdown_req), 32'h0);
      write_mask(SW'(1) << (2 * P + 2));
      step(1);
      check("R8 therm irq", 32'(fault_irq), 32'h1);
      supply_ok = 1'b0;
      step(1);
      check("R8 supply gate", 32'(fault_irq), 32'h0);
      supply_ok = 1'b1;
      therm_raw[1] = 1'b0;
      step(TF - 1);
      check("R6 release hold", 32'(fault_status[2 * P + 2]), 32'h1);
      step(1);
      check("R6 released", 32'(fault_status[2 * P + 2]), 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule